// File: doc/BRIEF.md
# Feed-Protected Watchdog Timer

This block is a watchdog down-counter that software must restart at regular intervals. A prescaler divides the selected count source and feeds the counter. The source is either the system clock or a pulse input from an always-on oscillator. When the counter passes zero it reloads and raises an event. If the reset-enable configuration input is set, that event is a one-cycle reset request. If it is clear, the event sets a timer flag that drives an interrupt request through an external enable.

Software reaches the block through a small byte-wide register bus with four addresses. Address 0 is control, 1 is reload, 2 is feed and 3 is status. To restart the counter, software writes the two-byte key to the feed address. Control writes are held in a staging register and take effect only when a good feed completes. If any other bus access breaks the key sequence, the block raises a reset request. The safety-enable configuration input, together with reset-enable, locks the block so that it always runs from the oscillator pulses.

Top module: `wdt_guard`

## Requirements
- R1: After reset release, control reads 0x04 (run bit 2 = 1, source bit 0 = 0, divider field bits 7:5 = 0), reload reads 0xFF and status reads 0x00. The counter runs at once: with no feed, the first reset request comes 8192 cycles after release.
- R2: With reset-enable set, an underflow drives rst_req_o high for exactly one cycle. The counter then reloads and keeps counting. From a feed with reload R and divider n on the system clock, the pulse comes 2^(n+5)*(R+1) cycles after the edge of the second feed write.
- R3: With the active run bit at 0, the prescaler and counter hold and no underflow occurs. Setting run back to 1 resumes counting.
- R4: A write to control (address 0) changes nothing until the next good feed. Until then, reads and timing follow the old settings.
- R5: The prescaler divides the selected source by 2^(n+5), where n is control bits 7:5.
- R6: With control bit 0 = 1, the prescaler advances only on cycles where osc_tick_i is high. When osc_tick_i is low, nothing advances.
- R7: With reset-enable clear, an underflow gives no reset request. It sets status bit 1 instead. irq_o equals status bit 1 AND irq_en_i. Writing 0 to status bit 1 clears it.
- R8: A good feed is a write of 0xA5 to address 2 with the next bus access being a write of 0x5A to address 2. It reloads the counter from the reload register and clears the prescaler.
- R9: Once 0xA5 has been written, any other next bus access (a read, a write elsewhere, or another value) aborts the feed. If reset-enable is set, it raises a reset request on the following cycle. If reset-enable is clear, it raises no reset request.
- R10: With safety-enable and reset-enable both set, the active run and source bits read as 1 and take effect as 1, and software writes to them have no effect. The counter advances only on osc_tick_i.
- R11: Status bit 0 is set together with every reset request. Writing 1 to it keeps it set; only writing 0 clears it.
- R12: The reload register (address 1) is written and read back at once, without a feed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| cfg_rst_en_i | input | 1 | Configuration: underflow resets the system |
| cfg_safe_i | input | 1 | Configuration: safety lock (used with cfg_rst_en_i) |
| osc_tick_i | input | 1 | One-cycle pulses from the always-on oscillator |
| irq_en_i | input | 1 | Interrupt enable from the interrupt controller |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Timer-mode interrupt request |

## Verification
The assertions check, on every cycle, the local invariants of the block. The active control register changes only on a good feed. A stopped counter and prescaler hold their values. A feed or an underflow loads the reload value. The key sequence disarms after it completes or aborts. A reset request appears only with reset-enable set and always with the sticky flag. In locked mode the counter steps only on an oscillator pulse. The bench scenarios are what show the end-to-end timing. These are the exact underflow periods for different reload and divider values, the deferred effect of a control write, the abort cases that break the key sequence, and the irq_o gating in timer mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int PSEL_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_FEED   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 2'd3;

  localparam logic [DATA_W-1:0] KEY_ARM  = 8'hA5;
  localparam logic [DATA_W-1:0] KEY_FIRE = 8'h5A;

  localparam int SEL_BIT = 0;
  localparam int RUN_BIT = 2;
  localparam int PRE_LSB = 5;
  localparam int STAT_WD  = 0;
  localparam int STAT_TMR = 1;

  typedef struct packed {
    logic [PSEL_W-1:0] presc;
    logic              run;
    logic              sel;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    logic [DATA_W-1:0] r;
    r = '0;
    r[PRE_LSB +: PSEL_W] = c.presc;
    r[RUN_BIT] = c.run;
    r[SEL_BIT] = c.sel;
    return r;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] d);
    ctrl_t c;
    c.presc = d[PRE_LSB +: PSEL_W];
    c.run   = d[RUN_BIT];
    c.sel   = d[SEL_BIT];
    return c;
  endfunction
endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              feed_ok_o,
  output logic              feed_err_o
);
  logic armed_q, access, hit_arm, hit_fire;

  always_comb begin
    access   = wr_i | rd_i;
    hit_arm  = wr_i && (addr_i == ADR_FEED) && (wdata_i == KEY_ARM);
    hit_fire = wr_i && (addr_i == ADR_FEED) && (wdata_i == KEY_FIRE);
    feed_ok_o  = armed_q & hit_fire;
    feed_err_o = armed_q & access & ~hit_fire;
  end

  // any access while armed ends the sequence; only an unarmed 0xA5 arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (access) armed_q <= hit_arm & ~armed_q;
  end

  p_disarm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed_ok_o || feed_err_o) |=> !armed_q);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int                CNT_W   = 8,
  parameter logic [PSEL_W-1:0] PRE_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              feed_ok_i,
  input  logic              lock_i,
  input  logic              rst_evt_i,
  input  logic              tmr_evt_i,
  output logic              run_o,
  output logic              sel_o,
  output logic [PSEL_W-1:0] presc_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              wd_flag_o,
  output logic              tmr_flag_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam ctrl_t CTRL_RST = '{presc: PRE_RST, run: 1'b1, sel: 1'b0};

  ctrl_t            act_q, pnd_q, eff;
  logic             pnd_vld_q;
  logic [CNT_W-1:0] reload_q;
  logic             wd_q, tmr_q;
  logic             ctrl_wr, reload_wr, stat_wr;

  always_comb begin
    ctrl_wr   = wr_i && (addr_i == ADR_CTRL);
    reload_wr = wr_i && (addr_i == ADR_RELOAD);
    stat_wr   = wr_i && (addr_i == ADR_STAT);
    eff.presc = act_q.presc;
    eff.run   = act_q.run | lock_i;
    eff.sel   = act_q.sel | lock_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= CTRL_RST;
      pnd_q     <= CTRL_RST;
      pnd_vld_q <= 1'b0;
    end else if (ctrl_wr) begin
      pnd_q     <= ctrl_unpack(wdata_i);
      pnd_vld_q <= 1'b1;
    end else if (feed_ok_i) begin
      if (pnd_vld_q) act_q <= pnd_q;
      pnd_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reload_q <= '1;
    else if (reload_wr) reload_q <= wdata_i[CNT_W-1:0];
  end

  // set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_q  <= 1'b0;
      tmr_q <= 1'b0;
    end else begin
      if (rst_evt_i)                      wd_q <= 1'b1;
      else if (stat_wr && !wdata_i[STAT_WD]) wd_q <= 1'b0;
      if (tmr_evt_i)                       tmr_q <= 1'b1;
      else if (stat_wr && !wdata_i[STAT_TMR]) tmr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL:   rdata_o = ctrl_pack(eff);
      ADR_RELOAD: rdata_o = DATA_W'(reload_q);
      ADR_FEED:   rdata_o = '0;
      ADR_STAT: begin
        rdata_o[STAT_WD]  = wd_q;
        rdata_o[STAT_TMR] = tmr_q;
      end
      default:    rdata_o = '0;
    endcase
  end

  assign run_o      = eff.run;
  assign sel_o      = eff.sel;
  assign presc_o    = eff.presc;
  assign reload_o   = reload_q;
  assign wd_flag_o  = wd_q;
  assign tmr_flag_o = tmr_q;

  p_ctrl_staged_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !feed_ok_i |=> $stable(act_q));
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_q && !(stat_wr && !wdata_i[STAT_WD])) |=> wd_q);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int PRE_BASE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              sel_i,
  input  logic              osc_tick_i,
  input  logic              clr_i,
  input  logic [PSEL_W-1:0] presc_i,
  output logic              step_o
);
  localparam int PSEL_MAX = (1 << PSEL_W) - 1;
  localparam int PRE_W    = PRE_BASE + PSEL_MAX;

  logic [PRE_W-1:0] pre_q, lim;
  logic             tick, term;

  always_comb begin
    lim    = {PRE_W{1'b1}} >> (PSEL_MAX - int'(presc_i));
    tick   = run_i & (sel_i ? osc_tick_i : 1'b1);
    term   = (pre_q == lim);
    step_o = tick & term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick)   pre_q <= term ? '0 : pre_q + 1'b1;
  end

  p_halt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(pre_q));
  p_feed_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             feed_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign uf_o = step_i && (cnt_q == '0) && !feed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (feed_i)  cnt_q <= reload_i;
    else if (step_i)  cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  p_feed_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_i |=> (cnt_q == $past(reload_i)));
  p_uf_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |=> (cnt_q == $past(reload_i)));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !feed_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int                CNT_W    = 8,
  parameter int                PRE_BASE = 5,
  parameter logic [PSEL_W-1:0] PRE_RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_rst_en_i,
  input  logic              cfg_safe_i,
  input  logic              osc_tick_i,
  input  logic              irq_en_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  logic              feed_ok, feed_err, lock, run, sel, step, uf;
  logic              rst_evt, tmr_evt, wd_flag, tmr_flag, rst_req_q;
  logic [PSEL_W-1:0] presc;
  logic [CNT_W-1:0]  reload;

  always_comb begin
    lock    = cfg_safe_i & cfg_rst_en_i;
    rst_evt = (uf | feed_err) & cfg_rst_en_i;
    tmr_evt = uf & ~cfg_rst_en_i;
  end

  wdt_feed_seq u_feed (
    .clk_i, .rst_ni,
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .feed_ok_o  (feed_ok),
    .feed_err_o (feed_err)
  );

  wdt_regs #(.CNT_W(CNT_W), .PRE_RST(PRE_RST)) u_regs (
    .clk_i, .rst_ni,
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .feed_ok_i  (feed_ok),
    .lock_i     (lock),
    .rst_evt_i  (rst_evt),
    .tmr_evt_i  (tmr_evt),
    .run_o      (run),
    .sel_o      (sel),
    .presc_o    (presc),
    .reload_o   (reload),
    .wd_flag_o  (wd_flag),
    .tmr_flag_o (tmr_flag),
    .rdata_o    (bus_rdata_o)
  );

  wdt_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
    .clk_i, .rst_ni,
    .run_i      (run),
    .sel_i      (sel),
    .osc_tick_i (osc_tick_i),
    .clr_i      (feed_ok),
    .presc_i    (presc),
    .step_o     (step)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .step_i   (step),
    .feed_i   (feed_ok),
    .reload_i (reload),
    .uf_o     (uf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= rst_evt;
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = tmr_flag & irq_en_i;

  p_rst_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(cfg_rst_en_i));
  p_rst_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> wd_flag);
  p_lock_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && step) |-> osc_tick_i);
  p_tmr_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_flag) |-> !$past(cfg_rst_en_i));
endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_rst_en = 1'b1, cfg_safe = 1'b0, osc_tick = 1'b0, irq_en = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rst_req, irq;
  logic       osc_on = 1'b0;
  int         checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_rst_en_i(cfg_rst_en), .cfg_safe_i(cfg_safe),
    .osc_tick_i(osc_tick), .irq_en_i(irq_en), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rst_req_o(rst_req), .irq_o(irq)
  );

  // oscillator pulse every 4th cycle while enabled
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (osc_on) begin
        ph = (ph + 1) % 4;
        osc_tick = (ph == 0);
      end else osc_tick = 1'b0;
    end
  end

  function automatic int exp_period(int n, int r);
    return (1 << (n + 5)) * (r + 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic bus_wr_t(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_rd_t(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic feed();
    bus_wr_t(2'd2, 8'hA5);
    bus_wr_t(2'd2, 8'h5A);
  endtask

  // which: 0 = reset request, 1 = irq; n = cycle of first hit (0 if none)
  task automatic wait_evt(input int which, input int max, output int n, output bit rst_seen);
    n = 0; rst_seen = 1'b0;
    for (int i = 1; i <= max; i++) begin
      @(posedge clk); #1;
      if (rst_req) rst_seen = 1'b1;
      if ((which == 0 && rst_req) || (which == 1 && irq)) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n, r, p, dummy;
    bit seen;
    logic [7:0] d;
    dummy = $urandom(32'h5EED_0042);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: running straight from reset, default period
    wait_evt(0, 9000, n, seen);
    chk("R1 first reset after release", n, 8192);
    @(posedge clk); #1;
    chk("R2 reset pulse one cycle", int'(rst_req), 0);
    bus_rd_t(2'd0, d); chk("R1 ctrl reset value", d, 8'h04);
    bus_rd_t(2'd1, d); chk("R1 reload reset value", d, 8'hFF);
    bus_rd_t(2'd3, d); chk("R11 wd flag set by reset request", d, 8'h01);

    // R11: write 1 keeps, write 0 clears
    bus_wr_t(2'd3, 8'h01); bus_rd_t(2'd3, d); chk("R11 write 1 keeps flag", d, 8'h01);
    bus_wr_t(2'd3, 8'h00); bus_rd_t(2'd3, d); chk("R11 write 0 clears flag", d, 8'h00);

    // R12
    bus_wr_t(2'd1, 8'h05); bus_rd_t(2'd1, d); chk("R12 reload readback", d, 8'h05);

    // R8 / R2: period from feed
    feed();
    wait_evt(0, 1000, n, seen);
    chk("R8 period after feed", n, exp_period(0, 5));

    // R4: staged control write
    feed();
    bus_wr_t(2'd0, 8'h24);
    wait_evt(0, 1000, n, seen);
    chk("R4 old divider still in force", n, exp_period(0, 5) - 1);
    bus_rd_t(2'd0, d); chk("R4 ctrl unchanged before feed", d, 8'h04);
    feed();
    bus_rd_t(2'd0, d); chk("R4 ctrl committed by feed", d, 8'h24);
    feed();
    wait_evt(0, 1000, n, seen);
    chk("R5 divider n=1 period", n, exp_period(1, 5));

    // R5 / R2 constrained random: reload 0..7, n 0..1
    for (int k = 0; k < 6; k++) begin
      int rn, rr;
      rn = int'($urandom % 2);
      rr = int'($urandom % 8);
      bus_wr_t(2'd0, 8'(8'h04 | (rn << 5)));
      bus_wr_t(2'd1, 8'(rr));
      feed();
      wait_evt(0, 2000, n, seen);
      chk("R5 random period", n, exp_period(rn, rr));
    end
    bus_wr_t(2'd0, 8'h04); bus_wr_t(2'd1, 8'h05); feed();

    // R3: stop and resume
    bus_wr_t(2'd0, 8'h00); feed();
    wait_evt(0, 2000, n, seen);
    chk("R3 stopped: no reset", int'(seen), 0);
    bus_wr_t(2'd0, 8'h04); feed();
    wait_evt(0, 1000, n, seen);
    chk("R3 resumed period", n, exp_period(0, 5));

    // R6: oscillator source
    bus_wr_t(2'd0, 8'h05); bus_wr_t(2'd1, 8'h01);
    osc_on = 1'b1;
    feed();
    wait_evt(0, 2000, n, seen);
    chk_rng("R6 osc source period", n, 4 * exp_period(0, 1) - 4, 4 * exp_period(0, 1) + 4);
    osc_on = 1'b0;
    feed();
    wait_evt(0, 1000, n, seen);
    chk("R6 no osc pulses: no reset", int'(seen), 0);
    bus_wr_t(2'd0, 8'h04); bus_wr_t(2'd1, 8'h05); feed();

    // R9: feed aborts with reset enabled
    feed();
    bus_wr_t(2'd2, 8'hA5);
    bus_rd_t(2'd1, d);
    chk("R9 read aborts feed", int'(rst_req), 1);
    bus_wr_t(2'd2, 8'hA5);
    bus_wr_t(2'd1, 8'h5A);
    chk("R9 write elsewhere aborts feed", int'(rst_req), 1);
    bus_rd_t(2'd3, d); chk("R11 flag after feed error", d, 8'h01);
    bus_wr_t(2'd1, 8'h05); feed();

    // R7: timer mode
    cfg_rst_en = 1'b0; irq_en = 1'b1;
    bus_wr_t(2'd3, 8'h00);
    feed();
    wait_evt(1, 1000, n, seen);
    chk("R7 irq at underflow", n, exp_period(0, 5));
    chk("R7 no reset in timer mode", int'(seen), 0);
    irq_en = 1'b0; #1;
    chk("R7 irq gated by enable", int'(irq), 0);
    bus_rd_t(2'd3, d); chk("R7 timer flag in status", d, 8'h02);
    irq_en = 1'b1;
    bus_wr_t(2'd3, 8'h01); #1;
    chk("R7 clear timer flag drops irq", int'(irq), 0);
    bus_wr_t(2'd2, 8'hA5);
    bus_rd_t(2'd1, d);
    chk("R9 abort without reset enable", int'(rst_req), 0);
    irq_en = 1'b0;
    cfg_rst_en = 1'b1;
    feed();

    // R10: safety lock
    cfg_safe = 1'b1;
    bus_rd_t(2'd0, d); chk("R10 locked ctrl reads run and source", d, 8'h05);
    bus_wr_t(2'd0, 8'h20); feed();
    bus_rd_t(2'd0, d); chk("R10 writes to run/source ignored", d, 8'h25);
    feed();
    wait_evt(0, 1000, n, seen);
    chk("R10 locked: counts only osc pulses", int'(seen), 0);
    osc_on = 1'b1;
    feed();
    wait_evt(0, 3000, n, seen);
    chk_rng("R10 locked period on osc", n, 4 * exp_period(1, 5) - 4, 4 * exp_period(1, 5) + 4);

    summary();
    $finish;
  end
endmodule